// File: doc/BRIEF.md
# GPIO Edge Interrupt Flag Unit

This block watches two 8-bit input ports and turns chosen signal edges on their pins into sticky interrupt flags. Every pin has its own flag, its own enable bit and its own edge-polarity bit. A flag is set only when the pin's enable bit is 1 and the pin makes the transition chosen by its polarity bit. Software reads the flags over a simple byte-wide register bus and clears them by writing ones.

Each port drives one level interrupt request towards an external interrupt controller. The request stays high while any flag of that port is set and enabled. It drops only when software clears the flags or masks them. Pin inputs are asynchronous and pass through a synchroniser chain before edge detection.

Register offsets on the bus are `0x10*p + k` for port `p`. Here `k = 5` is the enable byte, `k = 6` is the edge-polarity byte and `k = 7` is the flag byte. Bit `i` of each byte belongs to pin `i` of that port.

Top module: `gpio_edge_irq`

## Requirements
- R1: After reset, the enable, polarity and flag bytes of both ports read 0x00 and both request outputs are 0.
- R2: With polarity bit 0 and enable bit 1, a 0-to-1 transition on a pin sets its flag. A 1-to-0 transition does not set it.
- R3: With polarity bit 1 and enable bit 1, a 1-to-0 transition on a pin sets its flag. A 0-to-1 transition does not set it.
- R4: A pin whose enable bit is 0 never sets its flag, whatever its transitions are.
- R5: Writing the flag byte clears every flag whose written bit is 1. Flags whose written bit is 0 keep their value.
- R6: The request output of port `p` (bit `p` of `irqReq`) is high exactly when some flag of that port is 1 while its enable bit is 1. It stays high until the flag is cleared or the enable bit is cleared.
- R7: If a selected edge and a write-1 clear hit the same flag in the same cycle, the flag ends up set.
- R8: Register writes and pin activity on one port leave the other port's registers unchanged. Writes to unmapped offsets change no register, and reads from unmapped offsets return 0x00.
- R9: A pin change applied between clock edges sets its flag at the third rising clock edge after the change, and not at the second. This is two synchroniser stages plus one stage for the previous sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pinIn | input | 16 | Raw pin levels. Bits 8p+7..8p belong to port p |
| busAddr | input | 8 | Register byte address |
| busWe | input | 1 | Write strobe, taken at the rising clock edge |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Combinational read data for busAddr |
| irqReq | output | 2 | Level interrupt request, one bit per port |

## Verification
The main function is driven from a vector table. Each vector sets a polarity byte and an enable byte, then moves a whole port from one pin pattern to another. All-rising and all-falling swings under each polarity show that the polarity bit picks the edge and does not just pass any change through. Partial enable masks show the enable gating, and a mixed-polarity pattern on port 1 shows that bits are handled one by one. Directed tests then pin down the exact flag latency, selective clear with 0 and 1 bits, masking the request while the flag is kept, a clear that collides with a new edge, and writes to unmapped offsets.

// File: rtl/gei_pkg.sv
package gei_pkg;
  // Width of the port-number field carried in the bus strobe.
  localparam int PORT_IDX_W = 4;
  // Low-nibble offsets of the per-port registers.
  localparam int EN_OFS   = 5;
  localparam int SEL_OFS  = 6;
  localparam int FLAG_OFS = 7;

  typedef enum logic [1:0] {RK_NONE, RK_EN, RK_SEL, RK_FLAG} regKind_e;

  typedef struct packed {
    logic                  we;
    regKind_e              kind;
    logic [PORT_IDX_W-1:0] port;
  } busStrb_t;
endpackage

// File: rtl/gei_ctrl.sv
module gei_ctrl
  import gei_pkg::*;
#(
  parameter int NPORT  = 2,
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  output busStrb_t          strb
);
  localparam int OFS_W = 4;
  localparam int SEL_W = ADDR_W - OFS_W;

  logic [OFS_W-1:0] ofs;
  logic [SEL_W-1:0] portSel;

  assign ofs     = busAddr[OFS_W-1:0];
  assign portSel = busAddr[ADDR_W-1:OFS_W];

  always_comb begin
    strb.port = PORT_IDX_W'(portSel);
    strb.kind = RK_NONE;
    if (int'(portSel) < NPORT) begin
      case (ofs)
        OFS_W'(EN_OFS):   strb.kind = RK_EN;
        OFS_W'(SEL_OFS):  strb.kind = RK_SEL;
        OFS_W'(FLAG_OFS): strb.kind = RK_FLAG;
        default:          strb.kind = RK_NONE;
      endcase
    end
    strb.we = busWe && (strb.kind != RK_NONE);
  end
endmodule

// File: rtl/gei_edge_sync.sv
module gei_edge_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] pinRaw,
  input  logic [W-1:0] fallSel,
  output logic [W-1:0] edgeHit
);
  localparam int LAST = STAGES - 1;

  logic [W-1:0] stageQ [STAGES];
  logic [W-1:0] prevQ;
  logic [W-1:0] rise;
  logic [W-1:0] fall;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < STAGES; i++) stageQ[i] <= '0;
      prevQ <= '0;
    end else begin
      stageQ[0] <= pinRaw;
      for (int i = 1; i < STAGES; i++) stageQ[i] <= stageQ[i-1];
      prevQ <= stageQ[LAST];
    end
  end

  assign rise    = stageQ[LAST] & ~prevQ;
  assign fall    = ~stageQ[LAST] & prevQ;
  assign edgeHit = (fallSel & fall) | (~fallSel & rise);
endmodule

// File: rtl/gei_datapath.sv
module gei_datapath
  import gei_pkg::*;
#(
  parameter int NPORT       = 2,
  parameter int PW          = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NPORT*PW-1:0] pinIn,
  input  logic [PW-1:0]       busWdata,
  input  busStrb_t            strb,
  output logic [PW-1:0]       rdData,
  output logic [NPORT-1:0]    irqReq,
  output logic [NPORT*PW-1:0] flagAll,
  output logic [NPORT*PW-1:0] enAll
);
  logic [NPORT*PW-1:0] selAll;

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    logic [PW-1:0] enQ, selQ, flagQ, hit, clr;
    logic          wrHit;

    assign wrHit = strb.we && (strb.port == PORT_IDX_W'(p));

    gei_edge_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_edge (
      .clk     (clk),
      .rstN    (rstN),
      .pinRaw  (pinIn[p*PW +: PW]),
      .fallSel (selQ),
      .edgeHit (hit)
    );

    assign clr = (wrHit && strb.kind == RK_FLAG) ? busWdata : '0;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        enQ   <= '0;
        selQ  <= '0;
        flagQ <= '0;
      end else begin
        if (wrHit && strb.kind == RK_EN)  enQ  <= busWdata;
        if (wrHit && strb.kind == RK_SEL) selQ <= busWdata;
        // a fresh edge outranks a same-cycle clear
        flagQ <= (flagQ & ~clr) | (hit & enQ);
      end
    end

    assign irqReq[p]           = |(flagQ & enQ);
    assign flagAll[p*PW +: PW] = flagQ;
    assign enAll[p*PW +: PW]   = enQ;
    assign selAll[p*PW +: PW]  = selQ;
  end

  always_comb begin
    rdData = '0;
    for (int p = 0; p < NPORT; p++) begin
      if (strb.port == PORT_IDX_W'(p)) begin
        case (strb.kind)
          RK_EN:   rdData = enAll[p*PW +: PW];
          RK_SEL:  rdData = selAll[p*PW +: PW];
          RK_FLAG: rdData = flagAll[p*PW +: PW];
          default: rdData = '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/gpio_edge_irq.sv
module gpio_edge_irq
  import gei_pkg::*;
#(
  parameter int NPORT       = 2,
  parameter int PW          = 8,
  parameter int ADDR_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NPORT*PW-1:0] pinIn,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic                busWe,
  input  logic [PW-1:0]       busWdata,
  output logic [PW-1:0]       busRdata,
  output logic [NPORT-1:0]    irqReq
);
  busStrb_t            strb;
  logic [NPORT*PW-1:0] flagAll;
  logic [NPORT*PW-1:0] enAll;

  gei_ctrl #(.NPORT(NPORT), .ADDR_W(ADDR_W)) u_ctrl (
    .busAddr (busAddr),
    .busWe   (busWe),
    .strb    (strb)
  );

  gei_datapath #(.NPORT(NPORT), .PW(PW), .SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .pinIn    (pinIn),
    .busWdata (busWdata),
    .strb     (strb),
    .rdData   (busRdata),
    .irqReq   (irqReq),
    .flagAll  (flagAll),
    .enAll    (enAll)
  );
endmodule

// File: rtl/gei_checker.sv
module gei_checker #(
  parameter int NPORT  = 2,
  parameter int PW     = 8,
  parameter int ADDR_W = 8
) (
  input logic                clk,
  input logic                rstN,
  input logic [ADDR_W-1:0]   busAddr,
  input logic                busWe,
  input logic [PW-1:0]       busWdata,
  input logic [NPORT-1:0]    irqReq,
  input logic [NPORT*PW-1:0] flagAll,
  input logic [NPORT*PW-1:0] enAll
);
  logic [NPORT*PW-1:0] clrMask;

  always_comb begin
    clrMask = '0;
    for (int p = 0; p < NPORT; p++)
      if (busWe && busAddr == ADDR_W'(p * 16 + 7)) clrMask[p*PW +: PW] = busWdata;
  end

  // R1: reset leaves every flag cleared
  p_reset_clear_r1: assert property (@(posedge clk) !rstN |=> (flagAll == '0));

  // R4: a flag can only rise where the enable bit was set
  p_set_needs_en_r4: assert property (@(posedge clk) disable iff (!rstN)
    ((flagAll & ~$past(flagAll) & ~$past(enAll)) == '0));

  // R5: a flag can only fall through a write of 1 to its bit
  p_clear_needs_write_r5: assert property (@(posedge clk) disable iff (!rstN)
    (($past(flagAll) & ~flagAll & ~$past(clrMask)) == '0));

  for (genvar p = 0; p < NPORT; p++) begin : g_irq
    // R6: the request drops only after a bus write
    p_irq_drop_r6: assert property (@(posedge clk) disable iff (!rstN)
      $fell(irqReq[p]) |-> $past(busWe));
    // R6: the request rises only on a new flag or an enable write
    p_irq_rise_r6: assert property (@(posedge clk) disable iff (!rstN)
      $rose(irqReq[p]) |-> ($past(busWe) ||
        ($past(flagAll[p*PW +: PW]) != flagAll[p*PW +: PW])));
  end
endmodule

bind gpio_edge_irq gei_checker #(.NPORT(NPORT), .PW(PW), .ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .busAddr  (busAddr),
  .busWe    (busWe),
  .busWdata (busWdata),
  .irqReq   (irqReq),
  .flagAll  (flagAll),
  .enAll    (enAll)
);

// File: tb/gpio_edge_irq_bench.sv
module gpio_edge_irq_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] pins = '0;
  logic [7:0]  busAddr = '0;
  logic        busWe = 1'b0;
  logic [7:0]  busWdata = '0;
  logic [7:0]  busRdata;
  logic [1:0]  irqReq;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  gpio_edge_irq u_gpio_edge_irq (
    .clk(clk), .rstN(rstN), .pinIn(pins), .busAddr(busAddr), .busWe(busWe),
    .busWdata(busWdata), .busRdata(busRdata), .irqReq(irqReq)
  );

  typedef struct packed {
    logic [3:0] tag;
    logic       port;
    logic [7:0] sel;
    logic [7:0] en;
    logic [7:0] from;
    logic [7:0] to;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{4'd2, 1'b0, 8'h00, 8'hFF, 8'h00, 8'hFF},
    '{4'd2, 1'b0, 8'h00, 8'hFF, 8'hFF, 8'h00},
    '{4'd3, 1'b0, 8'hFF, 8'hFF, 8'hFF, 8'h00},
    '{4'd3, 1'b0, 8'hFF, 8'hFF, 8'h00, 8'hFF},
    '{4'd4, 1'b0, 8'h00, 8'h0F, 8'h00, 8'hFF},
    '{4'd3, 1'b1, 8'hA5, 8'hFF, 8'h0F, 8'hF0},
    '{4'd4, 1'b1, 8'h00, 8'h3C, 8'h00, 8'hFF},
    '{4'd4, 1'b1, 8'hFF, 8'h00, 8'hFF, 8'h00}
  };

  function automatic string tagName(input logic [3:0] t);
    case (t)
      4'd2:    return "R2";
      4'd3:    return "R3";
      default: return "R4";
    endcase
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%02h expected=0x%02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWe = 1'b1;
    @(negedge clk);
    busWe = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    busAddr = a;
    #1 d = busRdata;
  endtask

  task automatic setPort(input int p, input logic [7:0] v);
    @(negedge clk);
    pins[p*8 +: 8] = v;
  endtask

  task automatic settle();
    repeat (4) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    logic [7:0] exp;
    logic [7:0] base;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;

    // R1: reset state of every register and both requests
    for (int p = 0; p < 2; p++) begin
      for (int k = 5; k <= 7; k++) begin
        rd(8'(p * 16 + k), d);
        chk("R1 reset register", d, 8'h00);
      end
    end
    chk("R1 reset irq", {6'd0, irqReq}, 8'h00);

    // Table-driven main function (R2, R3, R4, R6, R8)
    for (int v = 0; v < 8; v++) begin
      base = 8'(VECS[v].port) * 8'h10;
      wr(8'h05, 8'h00); wr(8'h15, 8'h00);
      setPort(int'(VECS[v].port), VECS[v].from);
      settle();
      wr(8'h07, 8'hFF); wr(8'h17, 8'hFF);
      wr(base + 8'h06, VECS[v].sel);
      wr(base + 8'h05, VECS[v].en);
      setPort(int'(VECS[v].port), VECS[v].to);
      settle();
      exp = VECS[v].en & ((VECS[v].sel & VECS[v].from & ~VECS[v].to) |
                          (~VECS[v].sel & ~VECS[v].from & VECS[v].to));
      rd(base + 8'h07, d);
      chk(tagName(VECS[v].tag), d, exp);
      chk("R6 irq follows flags", {7'd0, irqReq[VECS[v].port]}, {7'd0, exp != 8'h00});
      rd(8'h10 - base + 8'h07, d);
      chk("R8 other port flags untouched", d, 8'h00);
    end

    // Common setup: port 0 rising edges, pins low, flags clear
    wr(8'h15, 8'h00);
    wr(8'h06, 8'h00); wr(8'h05, 8'hFF);
    setPort(0, 8'h00); settle();
    wr(8'h07, 8'hFF);

    // R9: exact latency from pin change to flag
    busAddr = 8'h07;
    @(negedge clk); pins[0] = 1'b1;
    @(posedge clk); @(posedge clk); #1;
    chk("R9 flag not set after 2 edges", busRdata, 8'h00);
    @(posedge clk); #1;
    chk("R9 flag set after 3 edges", busRdata, 8'h01);

    // R5: selective clear
    setPort(0, 8'hFF); settle();
    rd(8'h07, d); chk("R5 all flags set", d, 8'hFF);
    wr(8'h07, 8'h00);
    rd(8'h07, d); chk("R5 write 0 keeps flags", d, 8'hFF);
    wr(8'h07, 8'h0F);
    rd(8'h07, d); chk("R5 write 1 clears only its bits", d, 8'hF0);
    chk("R6 irq still high", {7'd0, irqReq[0]}, 8'h01);

    // R6: masking drops the request, flag is kept
    wr(8'h05, 8'h0F);
    chk("R6 irq low when masked", {7'd0, irqReq[0]}, 8'h00);
    rd(8'h07, d); chk("R6 flags kept while masked", d, 8'hF0);
    wr(8'h05, 8'hFF);
    chk("R6 irq back on unmask", {7'd0, irqReq[0]}, 8'h01);
    wr(8'h07, 8'hF0);
    chk("R6 irq low after clear", {7'd0, irqReq[0]}, 8'h00);

    // R7: new edge wins over a same-cycle clear
    setPort(0, 8'h00); settle();
    wr(8'h07, 8'hFF);
    setPort(0, 8'h01); settle();
    setPort(0, 8'h00); settle();
    rd(8'h07, d); chk("R7 pre-set flag", d, 8'h01);
    @(negedge clk); pins[0] = 1'b1;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    busAddr = 8'h07; busWdata = 8'h01; busWe = 1'b1;
    @(negedge clk);
    busWe = 1'b0;
    #1 chk("R7 set wins over clear", busRdata, 8'h01);
    wr(8'h07, 8'h01);
    rd(8'h07, d); chk("R7 plain clear afterwards", d, 8'h00);

    // R8: unmapped offsets
    wr(8'h08, 8'hFF); wr(8'h04, 8'hAA); wr(8'h27, 8'hFF);
    rd(8'h05, d); chk("R8 enable unchanged", d, 8'hFF);
    rd(8'h06, d); chk("R8 polarity unchanged", d, 8'h00);
    rd(8'h08, d); chk("R8 unmapped reads 0", d, 8'h00);
    rd(8'h27, d); chk("R8 missing port reads 0", d, 8'h00);

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule